// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is the 16-bit control register file that sits between a simple CPU bus and a set of peripherals (display, sound, DMA, timers, keypad, interrupt logic). The CPU presents a byte address, a write enable, a byte-or-halfword size select and write data. Read data comes back combinationally for whatever address is on the bus. Every register has its own writable-bit mask, its own power-on value and its own read rule. Some registers are read-only, some are write-only, and some addresses are unused holes. One register holds interrupt flags that are cleared by writing ones. A master sound enable bit hides the sound control registers while it is clear.

The peripherals themselves sit outside the bank. They learn about register updates from a one-cycle write strobe that carries the register index. They feed status back through the line-number, key-line, channel-status and interrupt-raise inputs. A byte write to the power-control address produces a halt or stop request pulse and stores nothing.

Top module: `periph_regbank`

## Requirements
- R1: During and after reset the stored values are 0x0080 at 0x000 (display control), 0x0100 at 0x020 and 0x026 (affine scale terms), 0x0200 at 0x088 (sound bias), 0x03FF at 0x130 (keys, while reset is held), and 0 everywhere else.
- R2: A halfword write stores only the register's writable bits and keeps the rest. The masks are 0xFFF8 at 0x004 (display status), 0x007F at 0x060, 0xFF77 at 0x080, 0x00C7 at 0x102 (timer control), 0x5FFF at 0x204 (wait control), and 0xFFFF for the other plain registers.
- R3: The line counter at 0x006 reads {8'h00, lineNum}. Writes to it change nothing and raise no strobe.
- R4: At the sound master register 0x084 only bit 7 is stored. A read returns bit 7, chanOn in bits 3..0, and zeros elsewhere.
- R5: The interrupt flag register at 0x202 ORs in irqRaise every cycle. A write clears each bit written as 1 and keeps each bit written as 0. When a clear and a raise of the same bit happen in one cycle, the raise wins.
- R6: A byte write (byteSel=1) takes wrData[7:0] into the high lane when addr[0]=1 and into the low lane otherwise. It keeps the other lane's stored byte and then applies the normal mask. At 0x202 the other lane counts as zero, so its flags survive.
- R7: While bit 7 of 0x084 is clear, reads of 0x060, 0x062 and 0x080 return 0. Writes to them are still stored and show once the enable is set.
- R8: Reads of the DMA count register 0x0B8, and of the holes 0x066, 0x06E, 0x076, 0x07A, 0x07E, 0x086 and 0x08A, return 0.
- R9: The write-only DMA source register 0x0B0 and every unmapped address read as the OPEN_BUS parameter. A write to an unmapped address stores nothing and raises no strobe.
- R10: A byte write to 0x301 pulses haltReq for one cycle when wrData[7]=0, and pulses stopReq when it is 1. It stores nothing and raises no wrStrobe.
- R11: An accepted write pulses wrStrobe for exactly the cycle after the write edge, with wrIndex set to the register index. The indices are 0x000→0, 0x004→1, 0x006→2, 0x020→3, 0x026→4, 0x060→5, 0x062→6, 0x080→7, 0x084→8, 0x088→9, 0x0B0→10, 0x0B8→11, 0x102→12, 0x130→13, 0x200→14, 0x202→15, 0x204→16.
- R12: The key register at 0x130 is read-only. Once reset is released it shows keyLines (zero-extended) as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wrEn | input | 1 | Write enable for this cycle |
| byteSel | input | 1 | 1 = byte write, 0 = halfword write |
| wrData | input | 16 | Write data (byte writes use bits 7..0) |
| rdData | output | 16 | Combinational read data for addr |
| lineNum | input | 8 | Current display line from the video side |
| keyLines | input | 10 | Raw key line levels |
| chanOn | input | 4 | Sound channel activity flags |
| irqRaise | input | 16 | Interrupt flag set requests |
| wrStrobe | output | 1 | One-cycle pulse after an accepted write |
| wrIndex | output | IDX_W | Index of the written register |
| haltReq | output | 1 | Halt request pulse |
| stopReq | output | 1 | Stop request pulse |

## Verification
All-ones halfword writes expose each mask directly. Byte writes to either lane show whether the merge keeps the right neighbour byte and still applies the mask. Flag-register stimulus has three cases: raises alone, clears alone, and a clear and a raise of one bit in the same cycle, which pins down the priority between the two. Reads of the sound registers before and after setting the master enable separate stored content from the gate. Reads of holes, of the write-only registers and of unmapped space tell the zero answer apart from the open-bus answer.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int DATA_W = 16;
  localparam int NREG   = 17;
  localparam int IDX_W  = $clog2(NREG);

  localparam int IDX_MASTER = 8;
  localparam int IDX_FLAG   = 15;

  localparam logic [11:0] PWR_ADDR = 12'h301;

  typedef enum logic [2:0] {
    KIND_RW, KIND_LINE, KIND_WO_BUS, KIND_WO_ZERO, KIND_KEYS, KIND_FLAG, KIND_MASTER
  } regKind_t;

  typedef enum logic [1:0] {SRC_REG, SRC_ZERO, SRC_BUS} rdSrc_t;

  typedef struct packed {
    logic             wr;
    logic             byteWr;
    logic             hiLane;
    logic [IDX_W-1:0] idx;
    rdSrc_t           rdSrc;
  } ctrl_t;

  function automatic logic [11:0] regAddr(input int i);
    case (i)
      0:  return 12'h000;
      1:  return 12'h004;
      2:  return 12'h006;
      3:  return 12'h020;
      4:  return 12'h026;
      5:  return 12'h060;
      6:  return 12'h062;
      7:  return 12'h080;
      8:  return 12'h084;
      9:  return 12'h088;
      10: return 12'h0B0;
      11: return 12'h0B8;
      12: return 12'h102;
      13: return 12'h130;
      14: return 12'h200;
      15: return 12'h202;
      16: return 12'h204;
      default: return 12'hFFE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input int i);
    case (i)
      1:  return 16'hFFF8;
      2:  return 16'h0000;
      5:  return 16'h007F;
      7:  return 16'hFF77;
      8:  return 16'h0080;
      12: return 16'h00C7;
      13: return 16'h0000;
      16: return 16'h5FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regReset(input int i);
    case (i)
      0:    return 16'h0080;
      3, 4: return 16'h0100;
      9:    return 16'h0200;
      13:   return 16'h03FF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic regKind_t regKind(input int i);
    case (i)
      2:  return KIND_LINE;
      8:  return KIND_MASTER;
      10: return KIND_WO_BUS;
      11: return KIND_WO_ZERO;
      13: return KIND_KEYS;
      15: return KIND_FLAG;
      default: return KIND_RW;
    endcase
  endfunction

  function automatic logic regGated(input int i);
    return (i == 5) || (i == 6) || (i == 7);
  endfunction

  function automatic logic isHole(input logic [11:0] a);
    return (a == 12'h066) || (a == 12'h06E) || (a == 12'h076) || (a == 12'h07A) ||
           (a == 12'h07E) || (a == 12'h086) || (a == 12'h08A);
  endfunction

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic             wrEn,
  input  logic             byteSel,
  input  logic             wrBit7,
  input  logic             sndOn,
  output ctrl_t            ctrl,
  output logic             wrStrobe,
  output logic [IDX_W-1:0] wrIndex,
  output logic             haltReq,
  output logic             stopReq
);

  logic [11:0]     fullAddr;
  logic [11:0]     alignAddr;
  logic [NREG-1:0] hitVec;
  logic            hit;
  logic [IDX_W-1:0] hitIdx;
  regKind_t        kind;
  logic            writable;
  logic            pwrHit;

  assign fullAddr  = 12'(addr);
  assign alignAddr = {fullAddr[11:1], 1'b0};

  for (genvar g = 0; g < NREG; g++) begin : gDec
    assign hitVec[g] = (alignAddr == regAddr(g));
  end

  always_comb begin
    hit    = |hitVec;
    hitIdx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign kind     = regKind(int'(hitIdx));
  assign writable = hit && (kind != KIND_LINE) && (kind != KIND_KEYS);
  assign pwrHit   = wrEn && byteSel && (fullAddr == PWR_ADDR);

  always_comb begin
    ctrl.wr     = wrEn && writable;
    ctrl.byteWr = byteSel;
    ctrl.hiLane = fullAddr[0];
    ctrl.idx    = hitIdx;
    if (hit) begin
      if (kind == KIND_WO_BUS)                        ctrl.rdSrc = SRC_BUS;
      else if (kind == KIND_WO_ZERO)                  ctrl.rdSrc = SRC_ZERO;
      else if (regGated(int'(hitIdx)) && !sndOn)      ctrl.rdSrc = SRC_ZERO;
      else                                            ctrl.rdSrc = SRC_REG;
    end else if (isHole(alignAddr)) begin
      ctrl.rdSrc = SRC_ZERO;
    end else begin
      ctrl.rdSrc = SRC_BUS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
      haltReq  <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      wrStrobe <= ctrl.wr;
      wrIndex  <= ctrl.wr ? hitIdx : '0;
      haltReq  <= pwrHit && !wrBit7;
      stopReq  <= pwrHit && wrBit7;
    end
  end

endmodule

// File: rtl/regbank_data.sv
module regbank_data
  import regbank_pkg::*;
#(
  parameter logic [15:0] OPEN_BUS = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        lineNum,
  input  logic [9:0]        keyLines,
  input  logic [3:0]        chanOn,
  input  logic [DATA_W-1:0] irqRaise,
  output logic [DATA_W-1:0] rdData,
  output logic              sndOn,
  output logic [DATA_W-1:0] flagQ
);

  logic [NREG-1:0][DATA_W-1:0] regQ;
  logic [DATA_W-1:0] curQ;
  logic [DATA_W-1:0] keepQ;
  logic [DATA_W-1:0] wrVal;
  regKind_t          selKind;

  assign selKind = regKind(int'(ctrl.idx));
  assign curQ    = (int'(ctrl.idx) < NREG) ? regQ[ctrl.idx] : '0;
  assign keepQ   = (selKind == KIND_FLAG) ? '0 : curQ;

  always_comb begin
    if (!ctrl.byteWr)     wrVal = wrData;
    else if (ctrl.hiLane) wrVal = {wrData[7:0], keepQ[7:0]};
    else                  wrVal = {keepQ[15:8], wrData[7:0]};
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    localparam regKind_t          K = regKind(g);
    localparam logic [DATA_W-1:0] M = regMask(g);
    localparam logic [DATA_W-1:0] R = regReset(g);
    logic [DATA_W-1:0] q;
    logic hitW;
    assign hitW = ctrl.wr && (ctrl.idx == IDX_W'(g));

    if (K == KIND_KEYS) begin : gKeys
      always_ff @(posedge clk) begin
        if (rst) q <= R;
        else     q <= DATA_W'(keyLines);
      end
    end else if (K == KIND_FLAG) begin : gFlag
      always_ff @(posedge clk) begin
        if (rst) q <= R;
        else     q <= (q & ~(hitW ? wrVal : '0)) | irqRaise;
      end
    end else if (K == KIND_LINE) begin : gLine
      assign q = {8'h00, lineNum};
    end else begin : gStd
      always_ff @(posedge clk) begin
        if (rst)       q <= R;
        else if (hitW) q <= (q & ~M) | (wrVal & M);
      end
    end
    assign regQ[g] = q;
  end

  assign sndOn = regQ[IDX_MASTER][7];
  assign flagQ = regQ[IDX_FLAG];

  always_comb begin
    case (ctrl.rdSrc)
      SRC_ZERO: rdData = '0;
      SRC_BUS:  rdData = OPEN_BUS;
      default:  rdData = (selKind == KIND_MASTER) ? {8'h00, curQ[7], 3'b000, chanOn} : curQ;
    endcase
  end

endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import regbank_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [15:0] OPEN_BUS = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              byteSel,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [7:0]        lineNum,
  input  logic [9:0]        keyLines,
  input  logic [3:0]        chanOn,
  input  logic [15:0]       irqRaise,
  output logic              wrStrobe,
  output logic [IDX_W-1:0]  wrIndex,
  output logic              haltReq,
  output logic              stopReq
);

  ctrl_t       ctrl;
  logic        sndOn;
  logic [15:0] flagQ;

  regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .byteSel(byteSel),
    .wrBit7(wrData[7]), .sndOn(sndOn), .ctrl(ctrl), .wrStrobe(wrStrobe),
    .wrIndex(wrIndex), .haltReq(haltReq), .stopReq(stopReq)
  );

  regbank_data #(.OPEN_BUS(OPEN_BUS)) u_data (
    .clk(clk), .rst(rst), .ctrl(ctrl), .wrData(wrData), .lineNum(lineNum),
    .keyLines(keyLines), .chanOn(chanOn), .irqRaise(irqRaise),
    .rdData(rdData), .sndOn(sndOn), .flagQ(flagQ)
  );

endmodule

// File: rtl/periph_regbank_chk.sv
module periph_regbank_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              byteSel,
  input logic [15:0]       wrData,
  input logic [15:0]       rdData,
  input logic [7:0]        lineNum,
  input logic [15:0]       irqRaise,
  input logic [15:0]       flagQ,
  input logic              wrStrobe,
  input logic              haltReq,
  input logic              stopReq
);

  logic [11:0] a12;
  logic        flagWr;
  logic        holeA;
  assign a12    = {12'(addr) >> 1, 1'b0} [11:0];
  assign flagWr = wrEn && (a12 == 12'h202);
  assign holeA  = (a12 == 12'h066) || (a12 == 12'h06E) || (a12 == 12'h076) || (a12 == 12'h07A) ||
                  (a12 == 12'h07E) || (a12 == 12'h086) || (a12 == 12'h08A);

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (flagWr && !byteSel) |=> ((flagQ & $past(wrData) & ~$past(irqRaise)) == 16'h0)) else $error("flag clear"); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!flagWr) |=> ((flagQ & $past(flagQ)) == $past(flagQ))) else $error("flag dropped"); // R5
  AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (rst)
    (irqRaise != 16'h0) |=> ((flagQ & $past(irqRaise)) == $past(irqRaise))) else $error("raise lost"); // R5
  AST_PWR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(haltReq && stopReq)) else $error("halt and stop"); // R10
  AST_LINE_RO: assert property (@(posedge clk) disable iff (rst)
    (a12 == 12'h006) |-> (rdData == {8'h00, lineNum})) else $error("line read"); // R3
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    holeA |-> (rdData == 16'h0)) else $error("hole read"); // R8
  AST_STROBE_SRC: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |-> $past(wrEn)) else $error("stray strobe"); // R11

endmodule

bind periph_regbank periph_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .byteSel(byteSel), .wrData(wrData),
  .rdData(rdData), .lineNum(lineNum), .irqRaise(irqRaise), .flagQ(flagQ),
  .wrStrobe(wrStrobe), .haltReq(haltReq), .stopReq(stopReq)
);

// File: tb/periph_regbank_bench.sv
`timescale 1ns/1ps
module periph_regbank_bench;
  import regbank_pkg::*;

  localparam logic [15:0] OB = 16'hDEAD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        byteSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [7:0]  lineNum = 8'h5A;
  logic [9:0]  keyLines = 10'h155;
  logic [3:0]  chanOn = 4'hA;
  logic [15:0] irqRaise = '0;
  logic        wrStrobe;
  logic [IDX_W-1:0] wrIndex;
  logic        haltReq, stopReq;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic gStb, gHalt, gStop;
  logic [IDX_W-1:0] gIdx;

  always #2.5 clk = ~clk;

  periph_regbank u_periph_regbank (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .byteSel(byteSel), .wrData(wrData),
    .rdData(rdData), .lineNum(lineNum), .keyLines(keyLines), .chanOn(chanOn),
    .irqRaise(irqRaise), .wrStrobe(wrStrobe), .wrIndex(wrIndex),
    .haltReq(haltReq), .stopReq(stopReq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [9:0] a, input logic [15:0] d, input logic b,
                       input logic [15:0] irq = 16'h0);
    @(negedge clk);
    addr = a; wrData = d; byteSel = b; wrEn = 1'b1; irqRaise = irq;
    @(negedge clk);
    wrEn = 1'b0; byteSel = 1'b0; irqRaise = 16'h0;
    gStb = wrStrobe; gIdx = wrIndex; gHalt = haltReq; gStop = stopReq;
  endtask

  task automatic busRd(input logic [9:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic rdChk(input string req, input logic [9:0] a, input logic [15:0] exp);
    logic [15:0] v;
    busRd(a, v);
    chk(req, v, exp);
  endtask

  task automatic testReset();
    logic [15:0] v;
    v = 0;
    // R1: read while reset is held
    addr = 10'h000; #1 chk("R1 disp ctrl", rdData, 16'h0080);
    addr = 10'h020; #1 chk("R1 scale A", rdData, 16'h0100);
    addr = 10'h026; #1 chk("R1 scale D", rdData, 16'h0100);
    addr = 10'h088; #1 chk("R1 bias", rdData, 16'h0200);
    addr = 10'h130; #1 chk("R1 keys", rdData, 16'h03FF);
    addr = 10'h200; #1 chk("R1 irq enable", rdData, 16'h0000);
    @(negedge clk); rst = 1'b0;
    busRd(10'h130, v);
    chk("R12 keys sampled", v, 16'h0155);
  endtask

  task automatic testMasks();
    busWr(10'h004, 16'hFFFF, 1'b0); rdChk("R2 disp stat", 10'h004, 16'hFFF8);
    busWr(10'h102, 16'hFFFF, 1'b0); rdChk("R2 timer", 10'h102, 16'h00C7);
    busWr(10'h204, 16'hFFFF, 1'b0); rdChk("R2 wait", 10'h204, 16'h5FFF);
    busWr(10'h000, 16'h1234, 1'b0); rdChk("R2 disp ctrl", 10'h000, 16'h1234);
    busWr(10'h130, 16'h0000, 1'b0);
    chk("R12 no strobe on keys", {15'h0, gStb}, 16'h0);
    rdChk("R12 keys read-only", 10'h130, 16'h0155);
  endtask

  task automatic testSound();
    busWr(10'h060, 16'hFFFF, 1'b0);
    busWr(10'h062, 16'hABCD, 1'b0);
    busWr(10'h080, 16'hFFFF, 1'b0);
    rdChk("R7 gated lo", 10'h060, 16'h0000);
    rdChk("R7 gated hi", 10'h062, 16'h0000);
    rdChk("R4 master off", 10'h084, 16'h000A);
    busWr(10'h084, 16'hFFFF, 1'b0);
    rdChk("R4 master on", 10'h084, 16'h008A);
    rdChk("R7 open lo", 10'h060, 16'h007F);
    rdChk("R7 open hi", 10'h062, 16'hABCD);
    rdChk("R7 open mix", 10'h080, 16'hFF77);
  endtask

  task automatic testReadOnlyAndHoles();
    busWr(10'h006, 16'h1234, 1'b0);
    chk("R3 no strobe", {15'h0, gStb}, 16'h0);
    rdChk("R3 line", 10'h006, 16'h005A);
    busWr(10'h0B8, 16'h1111, 1'b0);
    rdChk("R8 dma count", 10'h0B8, 16'h0000);
    rdChk("R8 hole 066", 10'h066, 16'h0000);
    rdChk("R8 hole 07E", 10'h07E, 16'h0000);
    rdChk("R8 hole 08A", 10'h08A, 16'h0000);
    busWr(10'h0B0, 16'h4444, 1'b0);
    rdChk("R9 dma source", 10'h0B0, OB);
    busWr(10'h3F0, 16'h7777, 1'b0);
    chk("R9 no strobe", {15'h0, gStb}, 16'h0);
    rdChk("R9 unmapped", 10'h3F0, OB);
  endtask

  task automatic testFlags();
    @(negedge clk); irqRaise = 16'h00F3;
    @(negedge clk); irqRaise = 16'h0000;
    rdChk("R5 raise", 10'h202, 16'h00F3);
    busWr(10'h202, 16'h0031, 1'b0);
    rdChk("R5 clear", 10'h202, 16'h00C2);
    busWr(10'h202, 16'h0082, 1'b0, 16'h0002);
    rdChk("R5 raise wins", 10'h202, 16'h0042);
  endtask

  task automatic testBytes();
    busWr(10'h001, 16'h00AB, 1'b1); rdChk("R6 high lane", 10'h000, 16'hAB34);
    busWr(10'h000, 16'h0077, 1'b1); rdChk("R6 low lane", 10'h000, 16'hAB77);
    busWr(10'h004, 16'h000F, 1'b1); rdChk("R6 byte mask", 10'h004, 16'hFF08);
    busWr(10'h203, 16'h00FF, 1'b1); rdChk("R6 flag lane", 10'h202, 16'h0042);
  endtask

  task automatic testPower();
    busWr(10'h301, 16'h0000, 1'b1);
    chk("R10 halt", {13'h0, gHalt, gStop, gStb}, 16'h0004);
    busWr(10'h301, 16'h0080, 1'b1);
    chk("R10 stop", {13'h0, gHalt, gStop, gStb}, 16'h0002);
    @(negedge clk);
    chk("R10 pulse ends", {14'h0, haltReq, stopReq}, 16'h0);
  endtask

  task automatic testStrobe();
    busWr(10'h000, 16'h0001, 1'b0);
    chk("R11 disp strobe", {10'h0, gStb, gIdx}, {10'h0, 1'b1, 5'd0});
    busWr(10'h102, 16'h0001, 1'b0);
    chk("R11 timer strobe", {10'h0, gStb, gIdx}, {10'h0, 1'b1, 5'd12});
    busWr(10'h202, 16'h0000, 1'b0);
    chk("R11 flag strobe", {10'h0, gStb, gIdx}, {10'h0, 1'b1, 5'd15});
    @(negedge clk);
    chk("R11 one cycle", {15'h0, wrStrobe}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testMasks();
    testSound();
    testReadOnlyAndHoles();
    testFlags();
    testBytes();
    testPower();
    testStrobe();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule